// File: doc/BRIEF.md
# PCIe Configuration Access Remapper

This block sits between a configuration access engine and two memory-mapped configuration apertures of a PCIe root port. Each request names a bus, a device/function, a register offset, a byte size and, for writes, data. The block decides whether the target may be reached at all. It then steers the access to a local region, which holds the root port's own type-0 header, or to a remote region. The remote region is reached through an outbound window, and the block retargets that window at the bus/device/function being addressed.

The block keeps a cached copy of the last retarget word it wrote. It rewrites the window's low translation register only when a new target differs from that copy. This saves a register write on every repeated access to the same device. Right after reset the block clears the high and then the low translation register.

Three kinds of request are refused with a not-found status. These are requests made while the link has not reached its operational state, requests with a nonzero device number on the root side, and requests that arrive during the setup clears. A write to the primary-bus byte of the root port's own header has its low data byte forced to zero.

Top module: `pcie_cfg_remapper`

## Requirements
- R1: Only the low 12 bits of `req_offset` select the register. Upper offset bits have no effect, and `mem_addr` equals `{offset[11:2], 2'b00}`.
- R2: A request whose bus equals `first_bus` is an access to the local region (`mem_region` = 0) and never causes a window write.
- R3: When the bus equals `first_bus`, or the request's primary bus equals `first_bus`, any device/function with a bit set under mask 0xF8 is refused as not found (`rsp_ok` = 0) and makes no memory access. The function bits (mask 0x07) alone are accepted.
- R4: Any other accepted request goes to the remote region (`mem_region` = 1). If `{bus, devfn, 16'h0}` differs from the cached word, the block writes that word to the low translation register (`win_sel` = 0) and stores it as the new cached word. If the two are equal, no window write happens.
- R5: In the first cycle after reset release, the block writes zero to the high translation register (`win_sel` = 1). In the next cycle it writes zero to the low register. Requests sampled in these two cycles are refused as not found.
- R6: When `link_state` is below `L0_CODE` (default 0x11), every request is refused as not found.
- R7: A write to offset 0x018 on bus `first_bus` has bits 7:0 of its data cleared before lane placement. The same offset on other buses, and a byte write to 0x019, are not altered.
- R8: Size codes are 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. A byte sits in lane `offset[1:0]`, a halfword in lanes starting at `2*offset[1]`, and a word in all four lanes. The lanes are little-endian: lane n is data bits 8n+7:8n. `mem_be` marks the lanes. Read data is shifted down and zero-extended.
- R9: A refused read returns 0xFFFFFFFF. A refused request of either kind makes no memory access, no window write and no change to the cached word.
- R10: Reset sets the cached word to zero. A first remote access whose target word is zero (bus 0, devfn 0, with `first_bus` nonzero) therefore performs no window write.
- R11: A window write appears one cycle after the request is sampled. The memory access and the response (`rsp_valid`, `rsp_ok`, `rsp_rdata`) appear two cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| first_bus | input | 8 | Bus number of the root port |
| link_state | input | 6 | Current link training state code |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device (7:3) and function (2:0) |
| req_primary | input | 8 | Primary bus of the target bus |
| req_offset | input | 16 | Register offset; only bits 11:0 are used |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data, right-aligned |
| win_we | output | 1 | Window translation register write strobe |
| win_sel | output | 1 | 0 = low translation register, 1 = high |
| win_wdata | output | 32 | Translation value |
| mem_valid | output | 1 | Aperture access strobe |
| mem_write | output | 1 | Aperture access is a write |
| mem_region | output | 1 | 0 = local type-0 region, 1 = remote type-1 region |
| mem_addr | output | 12 | Dword-aligned offset within the region |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Aperture read data, same cycle as the access |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | 1 = success, 0 = not found |
| rsp_rdata | output | 32 | Read data, all ones when refused |

## Verification
The bench uses several kinds of stimulus, and each separates different faults:
- Local reads and writes at every byte and halfword position, and in all size codes, separate errors in lane placement and in the offset mask.
- A run of remote requests that alternates between repeated and fresh targets, including back-to-back changes, shows whether the window is rewritten only when the target changes and whether its write stays ahead of the access that needs it.
- Device numbers under the root, and under a bus whose primary is the root, tell the root-side filter apart from a plain bus compare.
- Writes around offset 0x018 on local and remote buses isolate the primary-byte mask.
- A link-down stretch, followed by a request to the same target, shows that refused requests leave the cached word alone.
- A second reset with a nonzero root bus number exposes the zero-initialised cache.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

   typedef enum logic {
      RGN_LOCAL  = 1'b0,
      RGN_REMOTE = 1'b1
   } rgn_e;

   typedef enum logic {
      WSEL_LO = 1'b0,
      WSEL_HI = 1'b1
   } wsel_e;

   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;

endpackage

// File: rtl/cfgr_filter.sv
module cfgr_filter #(
   parameter int                    BUS_W           = 8,
   parameter int                    DEVFN_W         = 8,
   parameter int                    LS_W            = 6,
   parameter logic [LS_W-1:0]       L0_CODE         = 6'h11,
   parameter logic [DEVFN_W-1:0]    DEV_MASK        = 8'hF8,
   parameter bit                    FILTER_ROOT_DEV = 1'b1
) (
   input  logic [BUS_W-1:0]   bus,
   input  logic [BUS_W-1:0]   first_bus,
   input  logic [BUS_W-1:0]   primary,
   input  logic [DEVFN_W-1:0] devfn,
   input  logic [LS_W-1:0]    link_state,
   input  logic               busy,
   output logic               reject,
   output logic               to_local
);

   logic link_up;
   logic dev_bad;

   assign to_local = (bus == first_bus);
   assign link_up  = (link_state >= L0_CODE);

   generate
      if (FILTER_ROOT_DEV) begin : g_root_filter
         assign dev_bad = ((bus == first_bus) || (primary == first_bus)) &&
                          (|(devfn & DEV_MASK));
      end else begin : g_no_filter
         logic unused_filter_in;
         assign unused_filter_in = ^{primary, devfn};
         assign dev_bad = 1'b0;
      end
   endgenerate

   assign reject = busy | ~link_up | dev_bad;

endmodule

// File: rtl/cfgr_lanes.sv
module cfgr_lanes #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]          size,
   input  logic [1:0]          off_lo,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W-1:0]   rword,
   output logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]   wlane,
   output logic [DATA_W-1:0]   rext
);
   import cfgr_pkg::*;

   localparam int NB = DATA_W / 8;
   localparam int LW = $clog2(NB) + 2;

   logic [LW-1:0]     shift_b;
   logic [LW-1:0]     nbytes;
   logic [DATA_W-1:0] keep;

   always_comb begin
      if (size == SZ_BYTE) begin
         shift_b = LW'(off_lo);
         nbytes  = LW'(1);
      end else if (size == SZ_HALF) begin
         shift_b = LW'({off_lo[1], 1'b0});
         nbytes  = LW'(2);
      end else begin
         shift_b = '0;
         nbytes  = LW'(NB);
      end
   end

   assign keep  = (DATA_W'(1) << {nbytes, 3'b000}) - DATA_W'(1);
   assign wlane = (wdata & keep) << {shift_b, 3'b000};
   assign rext  = (rword >> {shift_b, 3'b000}) & keep;

   generate
      for (genvar gi = 0; gi < NB; gi++) begin : g_lane
         assign be[gi] = (LW'(gi) >= shift_b) && (LW'(gi) < (shift_b + nbytes));
      end
   endgenerate

endmodule

// File: rtl/cfgr_window.sv
module cfgr_window #(
   parameter int BUS_W   = 8,
   parameter int DEVFN_W = 8,
   parameter int WIN_W   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic [BUS_W-1:0]   bus,
   input  logic [DEVFN_W-1:0] devfn,
   output logic               busy,
   output logic               win_we,
   output logic               win_sel,
   output logic [WIN_W-1:0]   win_wdata,
   output logic               win_upd
);
   import cfgr_pkg::*;

   localparam int STEPS = 2;
   localparam int CW    = $clog2(STEPS + 1);
   localparam int LOW_Z = WIN_W - BUS_W - DEVFN_W;

   logic [CW-1:0]    step_q;
   logic [WIN_W-1:0] cache_q;
   logic [WIN_W-1:0] target;
   logic             differs;

   assign target  = WIN_W'({bus, devfn}) << LOW_Z;
   assign differs = (target != cache_q);
   assign busy    = (step_q != CW'(STEPS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q    <= '0;
         cache_q   <= '0;
         win_we    <= 1'b0;
         win_sel   <= WSEL_LO;
         win_wdata <= '0;
         win_upd   <= 1'b0;
      end else if (busy) begin
         step_q    <= step_q + CW'(1);
         win_we    <= 1'b1;
         win_sel   <= (step_q == '0) ? WSEL_HI : WSEL_LO;
         win_wdata <= '0;
         win_upd   <= 1'b0;
      end else begin
         win_we    <= fire && differs;
         win_upd   <= fire && differs;
         win_sel   <= WSEL_LO;
         win_wdata <= target;
         if (fire) cache_q <= target;
      end
   end

   assert_setup_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (win_we && (win_wdata == '0)));

   assert_no_stray_win_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && !busy) |=> !win_we);

endmodule

// File: rtl/pcie_cfg_remapper.sv
module pcie_cfg_remapper #(
   parameter int              BUS_W     = 8,
   parameter int              DEVFN_W   = 8,
   parameter int              RAW_OFF_W = 16,
   parameter int              CFG_OFF_W = 12,
   parameter int              DATA_W    = 32,
   parameter int              LS_W      = 6,
   parameter logic [LS_W-1:0] L0_CODE   = 6'h11,
   parameter logic [11:0]     PRIM_OFF  = 12'h018,
   parameter bit              FILTER_ROOT_DEV = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BUS_W-1:0]     first_bus,
   input  logic [LS_W-1:0]      link_state,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [BUS_W-1:0]     req_bus,
   input  logic [DEVFN_W-1:0]   req_devfn,
   input  logic [BUS_W-1:0]     req_primary,
   input  logic [RAW_OFF_W-1:0] req_offset,
   input  logic [1:0]           req_size,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 win_we,
   output logic                 win_sel,
   output logic [DATA_W-1:0]    win_wdata,
   output logic                 mem_valid,
   output logic                 mem_write,
   output logic                 mem_region,
   output logic [CFG_OFF_W-1:0] mem_addr,
   output logic [DATA_W/8-1:0]  mem_be,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic                 rsp_valid,
   output logic                 rsp_ok,
   output logic [DATA_W-1:0]    rsp_rdata
);
   import cfgr_pkg::*;

   localparam int NB = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("pcie_cfg_remapper: DATA_W must be 32");
   end
   if (BUS_W + DEVFN_W + 16 != DATA_W) begin : g_bad_target_w
      $error("pcie_cfg_remapper: bus and devfn widths must fill the top half of a word");
   end
   if (RAW_OFF_W < CFG_OFF_W) begin : g_bad_off_w
      $error("pcie_cfg_remapper: RAW_OFF_W must cover CFG_OFF_W");
   end

   // stage 0: decode
   logic [CFG_OFF_W-1:0] off0;
   logic                 rej0, local0, busy, fire_remote, win_upd;
   logic [DATA_W-1:0]    wdata0;
   logic                 unused_off_hi;

   assign off0          = req_offset[CFG_OFF_W-1:0];
   assign unused_off_hi = ^req_offset[RAW_OFF_W-1:CFG_OFF_W];

   cfgr_filter #(
      .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .LS_W(LS_W), .L0_CODE(L0_CODE),
      .DEV_MASK(DEVFN_W'(8'hF8)), .FILTER_ROOT_DEV(FILTER_ROOT_DEV)
   ) filter_i (
      .bus(req_bus), .first_bus(first_bus), .primary(req_primary),
      .devfn(req_devfn), .link_state(link_state), .busy(busy),
      .reject(rej0), .to_local(local0)
   );

   assign fire_remote = req_valid && !rej0 && !local0;
   assign wdata0 = (req_write && local0 && (off0 == CFG_OFF_W'(PRIM_OFF))) ?
                   (req_wdata & ~DATA_W'(8'hFF)) : req_wdata;

   cfgr_window #(.BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .WIN_W(DATA_W)) window_i (
      .clk(clk), .rst_n(rst_n), .fire(fire_remote), .bus(req_bus),
      .devfn(req_devfn), .busy(busy), .win_we(win_we), .win_sel(win_sel),
      .win_wdata(win_wdata), .win_upd(win_upd)
   );

   // stage 1 and stage 2 registers
   logic                 s1_valid, s1_write, s1_rej;
   rgn_e                 s1_rgn;
   logic [CFG_OFF_W-1:0] s1_off;
   logic [1:0]           s1_size;
   logic [DATA_W-1:0]    s1_wdata;
   logic                 s2_valid, s2_write, s2_rej;
   rgn_e                 s2_rgn;
   logic [CFG_OFF_W-1:0] s2_off;
   logic [1:0]           s2_size;
   logic [DATA_W-1:0]    s2_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0; s1_write <= 1'b0; s1_rej <= 1'b0; s1_rgn <= RGN_LOCAL;
         s1_off   <= '0;   s1_size  <= '0;   s1_wdata <= '0;
         s2_valid <= 1'b0; s2_write <= 1'b0; s2_rej <= 1'b0; s2_rgn <= RGN_LOCAL;
         s2_off   <= '0;   s2_size  <= '0;   s2_wdata <= '0;
      end else begin
         s1_valid <= req_valid;
         s1_write <= req_write;
         s1_rej   <= rej0;
         s1_rgn   <= local0 ? RGN_LOCAL : RGN_REMOTE;
         s1_off   <= off0;
         s1_size  <= req_size;
         s1_wdata <= wdata0;
         s2_valid <= s1_valid;
         s2_write <= s1_write;
         s2_rej   <= s1_rej;
         s2_rgn   <= s1_rgn;
         s2_off   <= s1_off;
         s2_size  <= s1_size;
         s2_wdata <= s1_wdata;
      end
   end

   // stage 2: aperture access and response
   logic [NB-1:0]     be2;
   logic [DATA_W-1:0] wlane2, rext2;

   cfgr_lanes #(.DATA_W(DATA_W)) lanes_i (
      .size(s2_size), .off_lo(s2_off[1:0]), .wdata(s2_wdata),
      .rword(mem_rdata), .be(be2), .wlane(wlane2), .rext(rext2)
   );

   assign mem_valid  = s2_valid && !s2_rej;
   assign mem_write  = s2_write;
   assign mem_region = s2_rgn;
   assign mem_addr   = {s2_off[CFG_OFF_W-1:2], 2'b00};
   assign mem_be     = be2;
   assign mem_wdata  = wlane2;
   assign rsp_valid  = s2_valid;
   assign rsp_ok     = !s2_rej;
   assign rsp_rdata  = s2_rej ? '1 : (s2_write ? '0 : rext2);

   assert_reject_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_rej) |=> !mem_valid);

   assert_win_before_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
      win_upd |=> (mem_valid && (mem_region == 1'b1)));

   assert_link_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (link_state < L0_CODE)) |-> ##2 (rsp_valid && !rsp_ok));

   assert_lane_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (($countones(mem_be) == 1) || ($countones(mem_be) == 2) ||
                     ($countones(mem_be) == 4)));

   assert_primary_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write && (mem_region == 1'b0) &&
       (mem_addr == {PRIM_OFF[CFG_OFF_W-1:2], 2'b00}) && mem_be[0])
      |-> (mem_wdata[7:0] == 8'h00));

endmodule

// File: tb/pcie_cfg_remapper_tb_top.sv
`timescale 1ns/1ps
module pcie_cfg_remapper_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  first_bus = 8'h00;
   logic [5:0]  link_state = 6'h11;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_bus = '0, req_devfn = '0, req_primary = '0;
   logic [15:0] req_offset = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        win_we, win_sel, mem_valid, mem_write, mem_region, rsp_valid, rsp_ok;
   logic [31:0] win_wdata, mem_wdata, mem_rdata, rsp_rdata;
   logic [11:0] mem_addr;
   logic [3:0]  mem_be;

   always #5 clk = ~clk;

   assign mem_rdata = {7'h50, mem_region, 8'h3C, 4'h0, mem_addr};

   pcie_cfg_remapper dut_i (
      .clk(clk), .rst_n(rst_n), .first_bus(first_bus), .link_state(link_state),
      .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
      .req_devfn(req_devfn), .req_primary(req_primary), .req_offset(req_offset),
      .req_size(req_size), .req_wdata(req_wdata), .win_we(win_we),
      .win_sel(win_sel), .win_wdata(win_wdata), .mem_valid(mem_valid),
      .mem_write(mem_write), .mem_region(mem_region), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata)
   );

   int          vectors = 0, miscompares = 0, k = 0;
   logic [31:0] cache_m = '0;

   // expectations per cycle slot
   bit          ew_we [4];  bit ew_sel [4];  logic [31:0] ew_d [4];  string ew_tag [4];
   bit          em_v [4];   bit em_w [4];    bit em_r [4];
   logic [11:0] em_a [4];   logic [3:0] em_be [4];  logic [31:0] em_d [4];  string em_tag [4];
   bit          er_v [4];   bit er_ok [4];   bit er_rd [4];  logic [31:0] er_d [4];  string er_tag [4];

   function automatic void idle_slot(int i);
      ew_we[i] = 0; ew_sel[i] = 0; ew_d[i] = '0; ew_tag[i] = "R4 no window write";
      em_v[i] = 0; em_w[i] = 0; em_r[i] = 0; em_a[i] = '0; em_be[i] = '0; em_d[i] = '0;
      em_tag[i] = "R9 no access";
      er_v[i] = 0; er_ok[i] = 0; er_rd[i] = 0; er_d[i] = '0; er_tag[i] = "R11 no response";
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s cycle %0d: actual %h expected %h", tag, k, act, exp);
      end
   endtask

   task automatic check_slot();
      int i = k % 4;
      logic [31:0] lm;
      chk(win_we == ew_we[i], ew_tag[i], 32'(win_we), 32'(ew_we[i]));
      if (ew_we[i]) begin
         chk(win_sel == ew_sel[i], ew_tag[i], 32'(win_sel), 32'(ew_sel[i]));
         chk(win_wdata == ew_d[i], ew_tag[i], win_wdata, ew_d[i]);
      end
      chk(mem_valid == em_v[i], em_tag[i], 32'(mem_valid), 32'(em_v[i]));
      if (em_v[i]) begin
         chk(mem_write == em_w[i], em_tag[i], 32'(mem_write), 32'(em_w[i]));
         chk(mem_region == em_r[i], em_tag[i], 32'(mem_region), 32'(em_r[i]));
         chk(mem_addr == em_a[i], em_tag[i], 32'(mem_addr), 32'(em_a[i]));
         chk(mem_be == em_be[i], em_tag[i], 32'(mem_be), 32'(em_be[i]));
         if (em_w[i]) begin
            lm = {{8{em_be[i][3]}}, {8{em_be[i][2]}}, {8{em_be[i][1]}}, {8{em_be[i][0]}}};
            chk((mem_wdata & lm) == em_d[i], em_tag[i], mem_wdata & lm, em_d[i]);
         end
      end
      chk(rsp_valid == er_v[i], er_tag[i], 32'(rsp_valid), 32'(er_v[i]));
      if (er_v[i]) begin
         chk(rsp_ok == er_ok[i], er_tag[i], 32'(rsp_ok), 32'(er_ok[i]));
         if (er_rd[i]) chk(rsp_rdata == er_d[i], er_tag[i], rsp_rdata, er_d[i]);
      end
      idle_slot(i);
   endtask

   task automatic step(input bit v, input bit w, input logic [7:0] b, input logic [7:0] d,
                       input logic [7:0] p, input logic [15:0] o, input logic [1:0] sz,
                       input logic [31:0] wd, input string tag);
      int n, s, i1, i2;
      bit rej, loc;
      logic [31:0] msk, pat, wdm, tgt;
      logic [11:0] a12;
      check_slot();
      req_valid = v; req_write = w; req_bus = b; req_devfn = d; req_primary = p;
      req_offset = o; req_size = sz; req_wdata = wd;
      n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      s = (sz == 2'd0) ? int'(o[1:0]) : (sz == 2'd1) ? 2 * int'(o[1]) : 0;
      msk = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
      loc = (b == first_bus);
      rej = (k < 2) || (link_state < 6'h11) ||
            (((b == first_bus) || (p == first_bus)) && ((d & 8'hF8) != 8'h00));
      i1 = (k + 1) % 4; i2 = (k + 2) % 4;
      if (v) begin
         a12 = {o[11:2], 2'b00};
         pat = {7'h50, !loc, 8'h3C, 4'h0, a12};
         er_v[i2] = 1; er_ok[i2] = !rej; er_rd[i2] = !w; er_tag[i2] = tag;
         er_d[i2] = rej ? 32'hFFFF_FFFF : ((pat >> (8 * s)) & msk);
         if (!rej) begin
            wdm = (w && loc && (o[11:0] == 12'h018)) ? (wd & 32'hFFFF_FF00) : wd;
            em_v[i2] = 1; em_w[i2] = w; em_r[i2] = !loc; em_a[i2] = a12; em_tag[i2] = tag;
            em_be[i2] = 4'(((1 << n) - 1) << s);
            em_d[i2] = (wdm & msk) << (8 * s);
            if (!loc) begin
               tgt = {b, d, 16'h0000};
               if (tgt != cache_m) begin
                  ew_we[i1] = 1; ew_sel[i1] = 0; ew_d[i1] = tgt; ew_tag[i1] = tag;
                  cache_m = tgt;
               end
            end
         end
      end
      @(negedge clk);
      k++;
   endtask

   task automatic idle(input int cnt);
      for (int j = 0; j < cnt; j++) step(0, 0, 8'h00, 8'h00, 8'h00, 16'h0, 2'd0, 32'h0, "idle");
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req_valid = 1'b0;
      for (int i = 0; i < 4; i++) idle_slot(i);
      repeat (2) @(negedge clk);
      chk(win_we == 1'b0, "R5 reset state win_we", 32'(win_we), 32'h0);
      chk(mem_valid == 1'b0, "R5 reset state mem_valid", 32'(mem_valid), 32'h0);
      chk(rsp_valid == 1'b0, "R5 reset state rsp_valid", 32'(rsp_valid), 32'h0);
      rst_n = 1'b1;
      k = 0;
      cache_m = '0;
      ew_we[1] = 1; ew_sel[1] = 1; ew_d[1] = '0; ew_tag[1] = "R5 setup clears high";
      ew_we[2] = 1; ew_sel[2] = 0; ew_d[2] = '0; ew_tag[2] = "R5 setup clears low";
   endtask

   initial begin
      #2_000_000;
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R5: requests during setup are refused
      step(1, 0, 8'h03, 8'h00, 8'h00, 16'h004, 2'd2, 32'h0, "R5 busy read");
      step(1, 1, 8'h00, 8'h00, 8'h00, 16'h004, 2'd2, 32'h1, "R5 busy write");
      // R2 / R8 local accesses
      step(1, 0, 8'h00, 8'h00, 8'h00, 16'h010, 2'd2, 32'h0, "R2 local word read");
      step(1, 0, 8'h00, 8'h00, 8'h00, 16'h021, 2'd0, 32'h0, "R8 byte lane 1");
      step(1, 0, 8'h00, 8'h00, 8'h00, 16'h022, 2'd0, 32'h0, "R8 byte lane 2");
      step(1, 0, 8'h00, 8'h00, 8'h00, 16'h023, 2'd0, 32'h0, "R8 byte lane 3");
      step(1, 0, 8'h00, 8'h00, 8'h00, 16'h026, 2'd1, 32'h0, "R8 upper half");
      step(1, 0, 8'h00, 8'h00, 8'h00, 16'h024, 2'd1, 32'h0, "R8 lower half");
      step(1, 0, 8'h00, 8'h00, 8'h00, 16'h030, 2'd3, 32'h0, "R8 size code 3");
      step(1, 1, 8'h00, 8'h00, 8'h00, 16'h041, 2'd0, 32'hAABBCCDD, "R8 byte write");
      step(1, 1, 8'h00, 8'h00, 8'h00, 16'h042, 2'd1, 32'h11223344, "R8 half write");
      step(1, 1, 8'h00, 8'h00, 8'h00, 16'h044, 2'd2, 32'hCAFEF00D, "R8 word write");
      // R1 offset mask
      step(1, 0, 8'h00, 8'h00, 8'h00, 16'hF123, 2'd0, 32'h0, "R1 upper offset bits");
      step(1, 1, 8'h00, 8'h00, 8'h00, 16'h8FFC, 2'd2, 32'h01020304, "R1 top dword write");
      // R3 device filter
      step(1, 0, 8'h00, 8'h08, 8'h00, 16'h000, 2'd2, 32'h0, "R3 root device 1");
      step(1, 0, 8'h00, 8'h07, 8'h00, 16'h000, 2'd2, 32'h0, "R3 root function bits");
      step(1, 0, 8'h04, 8'h10, 8'h00, 16'h000, 2'd2, 32'h0, "R3 primary is root");
      step(1, 0, 8'h04, 8'h10, 8'h02, 16'h000, 2'd2, 32'h0, "R4 remote device 2");
      // R4 window retarget
      step(1, 0, 8'h03, 8'h00, 8'h01, 16'h008, 2'd2, 32'h0, "R4 new target");
      step(1, 0, 8'h03, 8'h00, 8'h01, 16'h00C, 2'd2, 32'h0, "R4 same target");
      step(1, 0, 8'h03, 8'h01, 8'h01, 16'h00C, 2'd0, 32'h0, "R4 function change");
      step(1, 1, 8'h05, 8'h00, 8'h01, 16'h010, 2'd2, 32'h55, "R4 back to back a");
      step(1, 1, 8'h06, 8'h00, 8'h01, 16'h010, 2'd2, 32'h66, "R4 back to back b");
      step(1, 0, 8'h05, 8'h00, 8'h01, 16'h014, 2'd1, 32'h0, "R4 back to back c");
      step(1, 0, 8'h06, 8'h00, 8'h01, 16'h016, 2'd1, 32'h0, "R4 back to back d");
      // R7 primary bus mask
      step(1, 1, 8'h00, 8'h00, 8'h00, 16'h018, 2'd2, 32'h12345678, "R7 word at 0x18");
      step(1, 1, 8'h00, 8'h00, 8'h00, 16'h018, 2'd0, 32'h000000AB, "R7 byte at 0x18");
      step(1, 1, 8'h00, 8'h00, 8'h00, 16'h019, 2'd0, 32'h000000CD, "R7 byte at 0x19");
      step(1, 1, 8'h06, 8'h00, 8'h01, 16'h018, 2'd2, 32'h9ABCDEF0, "R7 remote 0x18");
      // R6 / R9 link down
      link_state = 6'h10;
      step(1, 0, 8'h00, 8'h00, 8'h00, 16'h000, 2'd2, 32'h0, "R6 local link down");
      step(1, 0, 8'h09, 8'h00, 8'h01, 16'h000, 2'd2, 32'h0, "R6 remote link down");
      step(1, 1, 8'h09, 8'h00, 8'h01, 16'h004, 2'd2, 32'h77, "R9 refused write");
      link_state = 6'h3F;
      step(1, 0, 8'h06, 8'h00, 8'h01, 16'h020, 2'd2, 32'h0, "R9 cache kept");
      step(1, 0, 8'h09, 8'h00, 8'h01, 16'h020, 2'd2, 32'h0, "R9 target after link up");
      link_state = 6'h11;
      // mixed sweep
      for (int j = 0; j < 48; j++) begin
         step(1, j[0], 8'(j % 3), 8'((j * 5) % 24), 8'((j % 2) + 1), 16'(j * 37),
              2'(j % 4), 32'(j * 32'h01010101 + 32'h1357), "R4 R8 sweep");
      end
      idle(4);
      // R10 zero cache after second reset
      do_reset();
      first_bus = 8'h01;
      idle(2);
      step(1, 0, 8'h00, 8'h00, 8'h00, 16'h000, 2'd2, 32'h0, "R10 zero target");
      step(1, 0, 8'h01, 8'h00, 8'h00, 16'h004, 2'd2, 32'h0, "R2 root bus 1");
      step(1, 0, 8'h00, 8'h08, 8'h01, 16'h004, 2'd2, 32'h0, "R3 primary bus 1");
      step(1, 1, 8'h01, 8'h00, 8'h00, 16'h018, 2'd2, 32'hFFFFFFFF, "R7 root bus 1");
      idle(4);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule